// File: doc/BRIEF.md
# Exception Cause Detector and Vector Encoder

This block sits beside the completion stage of a simple in-order processor core. Each cycle it gathers decode flags, machine-state enables, translation-miss flags, a breakpoint comparison, a decrementer sign bit and an external management interrupt. It qualifies each condition by the relevant state bit and picks a single winner by fixed priority. It then presents a take strobe, the vector offset of the winning exception and a cause word for the saved-status register.

The decrementer request is edge-triggered. A rising sign bit that arrives while interrupts are disabled is held as pending until it can be taken. All outputs are registered: a decision made from the inputs at one clock edge appears on the outputs just after that edge. Pipeline flush, state saving and the translation buffers themselves sit outside the block.

Top module: `exc_vector_unit`

## Requirements
- R1: A synchronous active-high `rst` clears `take_exc`, `vec_off` and `cause` to zero. Outputs reflect the inputs sampled at the previous rising edge. When no cause is active, all three outputs are zero.
- R2: `dc_illegal` or `dc_trap` gives vector 0x00700. Cause bit 0 marks illegal and bit 2 marks trap. Every active program sub-cause (bits 0..2) is reported together.
- R3: The privileged sub-cause (cause bit 1, vector 0x00700) is raised only when `ms_user`=1 and either `dc_priv`=1 or `dc_sprmove`=1 with `dc_sprnum[9]`=1. `dc_sprnum[9]` is the most significant bit of the special-register number.
- R4: `dc_fpop` with `ms_fpen`=0 gives vector 0x00800 with cause bit 3. With `ms_fpen`=1 nothing is raised.
- R5: `dc_syscall` gives vector 0x00C00 with cause bit 5.
- R6: `ms_step`=1, or `dc_branch`=1 with `ms_brtrace`=1, gives vector 0x00D00 with cause bit 6.
- R7: `itlb_miss` gives 0x01000 with cause bit 7. `dtlb_ld_miss` gives 0x01100 with cause bit 8. `dtlb_st_miss` or `dtlb_st_dirty` (a store hit that must still set the changed bit) gives 0x01200 with cause bit 9.
- R8: When `bp_reg[31:2]` equals `cmp_addr[31:2]` and the enable bit `bp_reg[1]` is 1, the block gives vector 0x01300 with cause bit 10.
- R9: `mgmt_irq` gives vector 0x01400 with cause bit 11, and only while `ms_irqen`=1.
- R10: A 0-to-1 change of `dec_top` relative to the previous cycle gives vector 0x00900 with cause bit 4 when `ms_irqen`=1. A held high level does not retrigger. The value seen during reset counts as the previous value.
- R11: A decrementer edge that cannot be taken stays pending until it is taken. This covers an edge blocked by `ms_irqen`=0 and an edge that loses to a higher cause. The pending state clears in the cycle the decrementer exception is taken.
- R12: Priority runs from highest to lowest: instruction miss, data load miss, data store miss, program, FP unavailable, system call, trace, breakpoint, management interrupt, decrementer. Outside the program group, only the winner's cause bit is set.
- R13: Only the ten listed offsets are ever output. Reserved ranges and the FP-assist slot 0x00E00 never appear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| dc_illegal | input | 1 | Illegal opcode decoded |
| dc_priv | input | 1 | Privileged operation decoded |
| dc_trap | input | 1 | Trap condition met |
| dc_fpop | input | 1 | Floating-point operation (incl. loads, stores, moves) |
| dc_syscall | input | 1 | System call instruction |
| dc_branch | input | 1 | Completing instruction is a branch |
| dc_sprmove | input | 1 | Move to/from special register |
| dc_sprnum | input | SPRW (10) | Special-register number field |
| ms_user | input | 1 | User-privilege state bit |
| ms_fpen | input | 1 | Floating-point available bit |
| ms_irqen | input | 1 | External interrupt enable |
| ms_step | input | 1 | Single-step trace enable |
| ms_brtrace | input | 1 | Branch trace enable |
| dec_top | input | 1 | Decrementer most significant bit |
| itlb_miss | input | 1 | Instruction translation miss |
| dtlb_ld_miss | input | 1 | Data load translation miss |
| dtlb_st_miss | input | 1 | Data store translation miss |
| dtlb_st_dirty | input | 1 | Store hit needing changed-bit update |
| bp_reg | input | AW (32) | Breakpoint register (address bits and enable) |
| cmp_addr | input | AW (32) | Next-completing instruction address |
| mgmt_irq | input | 1 | System management interrupt request |
| take_exc | output | 1 | Exception taken this cycle |
| vec_off | output | VEC_W (20) | Vector offset |
| cause | output | 12 | Cause bits |

## Verification
The decrementer and the management interrupt are both asynchronous. Both can be requested in the same cycle, and the decrementer must not be lost when it loses. The bench raises `dec_top` together with `mgmt_irq` while `ms_irqen` is 1. It expects vector 0x01400 in the next cycle and 0x00900, served from the pending state, in the cycle after that. A second collision pairs a system call with single-step trace, and the system call vector is expected to win.

// File: rtl/exc_pkg.sv
package exc_pkg;
  localparam int NC    = 12;
  localparam int VEC_W = 20;
  localparam int IDX_W = $clog2(NC);

  localparam int C_ILL  = 0;
  localparam int C_PRV  = 1;
  localparam int C_TRP  = 2;
  localparam int C_FPU  = 3;
  localparam int C_DEC  = 4;
  localparam int C_SC   = 5;
  localparam int C_TRC  = 6;
  localparam int C_ITLB = 7;
  localparam int C_DLD  = 8;
  localparam int C_DST  = 9;
  localparam int C_IABR = 10;
  localparam int C_SMI  = 11;

  localparam logic [NC-1:0] PROG_MASK = NC'(7);

  // Highest priority first
  localparam int PRIO [NC] = '{C_ITLB, C_DLD, C_DST, C_ILL, C_PRV, C_TRP,
                               C_FPU, C_SC, C_TRC, C_IABR, C_SMI, C_DEC};

  function automatic logic [VEC_W-1:0] vec_of(input int idx);
    case (idx)
      C_ILL, C_PRV, C_TRP: vec_of = VEC_W'('h00700);
      C_FPU:  vec_of = VEC_W'('h00800);
      C_DEC:  vec_of = VEC_W'('h00900);
      C_SC:   vec_of = VEC_W'('h00C00);
      C_TRC:  vec_of = VEC_W'('h00D00);
      C_ITLB: vec_of = VEC_W'('h01000);
      C_DLD:  vec_of = VEC_W'('h01100);
      C_DST:  vec_of = VEC_W'('h01200);
      C_IABR: vec_of = VEC_W'('h01300);
      C_SMI:  vec_of = VEC_W'('h01400);
      default: vec_of = '0;
    endcase
  endfunction

  function automatic logic vec_legal(input logic [VEC_W-1:0] v);
    vec_legal = (v == VEC_W'('h00700)) || (v == VEC_W'('h00800)) ||
                (v == VEC_W'('h00900)) || (v == VEC_W'('h00C00)) ||
                (v == VEC_W'('h00D00)) || (v == VEC_W'('h01000)) ||
                (v == VEC_W'('h01100)) || (v == VEC_W'('h01200)) ||
                (v == VEC_W'('h01300)) || (v == VEC_W'('h01400));
  endfunction
endpackage

// File: rtl/exc_dec_track.sv
module exc_dec_track (
  input  logic clk,
  input  logic rst,
  input  logic dec_top,
  input  logic irq_en,
  input  logic dec_taken,
  output logic dec_req
);
  logic prev_q;
  logic pend_q;
  logic rise;
  logic want;

  assign rise    = dec_top & ~prev_q;
  assign want    = pend_q | rise;
  assign dec_req = want & irq_en;

  always_ff @(posedge clk) begin
    if (rst) begin
      prev_q <= dec_top;
      pend_q <= 1'b0;
    end else begin
      prev_q <= dec_top;
      pend_q <= want & ~dec_taken;
    end
  end

  // R11: a request that was wanted but not taken must still be pending
  a_r11_pend_kept: assert property (@(posedge clk) disable iff (rst)
    (want && !dec_taken) |=> pend_q);
endmodule

// File: rtl/exc_cond_detect.sv
module exc_cond_detect
  import exc_pkg::*;
#(
  parameter int AW   = 32,
  parameter int SPRW = 10
) (
  input  logic            dc_illegal,
  input  logic            dc_priv,
  input  logic            dc_trap,
  input  logic            dc_fpop,
  input  logic            dc_syscall,
  input  logic            dc_branch,
  input  logic            dc_sprmove,
  input  logic [SPRW-1:0] dc_sprnum,
  input  logic            ms_user,
  input  logic            ms_fpen,
  input  logic            ms_irqen,
  input  logic            ms_step,
  input  logic            ms_brtrace,
  input  logic            dec_req,
  input  logic            itlb_miss,
  input  logic            dtlb_ld_miss,
  input  logic            dtlb_st_miss,
  input  logic            dtlb_st_dirty,
  input  logic [AW-1:0]   bp_reg,
  input  logic [AW-1:0]   cmp_addr,
  input  logic            mgmt_irq,
  output logic [NC-1:0]   raw
);
  localparam int BP_EN = 1;
  localparam int BP_LO = 2;

  logic bp_hit;
  assign bp_hit = bp_reg[BP_EN] && (bp_reg[AW-1:BP_LO] == cmp_addr[AW-1:BP_LO]);

  always_comb begin
    raw         = '0;
    raw[C_ILL]  = dc_illegal;
    raw[C_PRV]  = ms_user & (dc_priv | (dc_sprmove & dc_sprnum[SPRW-1]));
    raw[C_TRP]  = dc_trap;
    raw[C_FPU]  = dc_fpop & ~ms_fpen;
    raw[C_DEC]  = dec_req;
    raw[C_SC]   = dc_syscall;
    raw[C_TRC]  = ms_step | (dc_branch & ms_brtrace);
    raw[C_ITLB] = itlb_miss;
    raw[C_DLD]  = dtlb_ld_miss;
    raw[C_DST]  = dtlb_st_miss | dtlb_st_dirty;
    raw[C_IABR] = bp_hit;
    raw[C_SMI]  = mgmt_irq & ms_irqen;
  end
endmodule

// File: rtl/exc_prio_sel.sv
module exc_prio_sel
  import exc_pkg::*;
(
  input  logic [NC-1:0]    raw,
  output logic             any,
  output logic [IDX_W-1:0] win,
  output logic [VEC_W-1:0] vec,
  output logic [NC-1:0]    cs
);
  always_comb begin
    any = 1'b0;
    win = '0;
    for (int k = NC - 1; k >= 0; k--) begin
      if (raw[PRIO[k]]) begin
        any = 1'b1;
        win = IDX_W'(PRIO[k]);
      end
    end
    vec = any ? vec_of(int'(win)) : '0;
    if (!any)
      cs = '0;
    else if (PROG_MASK[win])
      cs = raw & PROG_MASK;
    else
      cs = NC'(1) << win;
  end
endmodule

// File: rtl/exc_vector_unit.sv
module exc_vector_unit
  import exc_pkg::*;
#(
  parameter int AW   = 32,
  parameter int SPRW = 10
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             dc_illegal,
  input  logic             dc_priv,
  input  logic             dc_trap,
  input  logic             dc_fpop,
  input  logic             dc_syscall,
  input  logic             dc_branch,
  input  logic             dc_sprmove,
  input  logic [SPRW-1:0]  dc_sprnum,
  input  logic             ms_user,
  input  logic             ms_fpen,
  input  logic             ms_irqen,
  input  logic             ms_step,
  input  logic             ms_brtrace,
  input  logic             dec_top,
  input  logic             itlb_miss,
  input  logic             dtlb_ld_miss,
  input  logic             dtlb_st_miss,
  input  logic             dtlb_st_dirty,
  input  logic [AW-1:0]    bp_reg,
  input  logic [AW-1:0]    cmp_addr,
  input  logic             mgmt_irq,
  output logic             take_exc,
  output logic [VEC_W-1:0] vec_off,
  output logic [NC-1:0]    cause
);
  logic             dec_req;
  logic             dec_taken;
  logic [NC-1:0]    raw;
  logic             sel_any;
  logic [IDX_W-1:0] sel_win;
  logic [VEC_W-1:0] sel_vec;
  logic [NC-1:0]    sel_cs;

  assign dec_taken = sel_any && (int'(sel_win) == C_DEC);

  exc_dec_track u_dec (
    .clk(clk), .rst(rst), .dec_top(dec_top), .irq_en(ms_irqen),
    .dec_taken(dec_taken), .dec_req(dec_req)
  );

  exc_cond_detect #(.AW(AW), .SPRW(SPRW)) u_cond (
    .dc_illegal(dc_illegal), .dc_priv(dc_priv), .dc_trap(dc_trap),
    .dc_fpop(dc_fpop), .dc_syscall(dc_syscall), .dc_branch(dc_branch),
    .dc_sprmove(dc_sprmove), .dc_sprnum(dc_sprnum), .ms_user(ms_user),
    .ms_fpen(ms_fpen), .ms_irqen(ms_irqen), .ms_step(ms_step),
    .ms_brtrace(ms_brtrace), .dec_req(dec_req), .itlb_miss(itlb_miss),
    .dtlb_ld_miss(dtlb_ld_miss), .dtlb_st_miss(dtlb_st_miss),
    .dtlb_st_dirty(dtlb_st_dirty), .bp_reg(bp_reg), .cmp_addr(cmp_addr),
    .mgmt_irq(mgmt_irq), .raw(raw)
  );

  exc_prio_sel u_sel (
    .raw(raw), .any(sel_any), .win(sel_win), .vec(sel_vec), .cs(sel_cs)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      take_exc <= 1'b0;
      vec_off  <= '0;
      cause    <= '0;
    end else begin
      take_exc <= sel_any;
      vec_off  <= sel_vec;
      cause    <= sel_cs;
    end
  end

  a_r1_idle_quiet: assert property (@(posedge clk) disable iff (rst)
    !take_exc |-> (vec_off == '0 && cause == '0));

  a_r12_single_winner: assert property (@(posedge clk) disable iff (rst)
    take_exc |-> ($onehot0(cause & ~PROG_MASK) && cause != '0));

  a_r13_no_reserved: assert property (@(posedge clk) disable iff (rst)
    take_exc |-> vec_legal(vec_off));

  a_r9_smi_gated: assert property (@(posedge clk) disable iff (rst)
    (take_exc && cause[C_SMI]) |-> $past(ms_irqen));

  a_r10_dec_gated: assert property (@(posedge clk) disable iff (rst)
    (take_exc && cause[C_DEC]) |-> $past(ms_irqen));
endmodule

// File: tb/exc_vector_unit_tb.sv
module exc_vector_unit_tb;
  localparam int CLK_P = 10;
  localparam int NV    = 28;

  typedef struct packed {
    logic [16:0] fl;   // {ill,prv,trp,fpop,sc,br,sprm, user,fpen,irqen,step,brtr, itlb,dld,dst,dirty, smi}
    logic [9:0]  spr;
    logic [31:0] bk;
    logic [31:0] na;
    logic        tk;
    logic [19:0] vec;
    logic [11:0] cs;
    logic [7:0]  req;
  } vec_t;

  localparam vec_t TBL [NV] = '{
    '{17'b0000000_00000_0000_0, 10'h000, 32'h0, 32'h0, 1'b0, 20'h00000, 12'h000, 8'd1},  // R1 idle
    '{17'b1000000_00000_0000_0, 10'h000, 32'h0, 32'h0, 1'b1, 20'h00700, 12'h001, 8'd2},  // R2 illegal
    '{17'b0100000_10000_0000_0, 10'h000, 32'h0, 32'h0, 1'b1, 20'h00700, 12'h002, 8'd3},  // R3 priv user
    '{17'b0100000_00000_0000_0, 10'h000, 32'h0, 32'h0, 1'b0, 20'h00000, 12'h000, 8'd3},  // R3 priv supervisor
    '{17'b0000001_10000_0000_0, 10'h200, 32'h0, 32'h0, 1'b1, 20'h00700, 12'h002, 8'd3},  // R3 spr msb set
    '{17'b0000001_10000_0000_0, 10'h1FF, 32'h0, 32'h0, 1'b0, 20'h00000, 12'h000, 8'd3},  // R3 spr msb clear
    '{17'b1010000_00000_0000_0, 10'h000, 32'h0, 32'h0, 1'b1, 20'h00700, 12'h005, 8'd2},  // R2 illegal+trap
    '{17'b0001000_00000_0000_0, 10'h000, 32'h0, 32'h0, 1'b1, 20'h00800, 12'h008, 8'd4},  // R4 fp off
    '{17'b0001000_01000_0000_0, 10'h000, 32'h0, 32'h0, 1'b0, 20'h00000, 12'h000, 8'd4},  // R4 fp on
    '{17'b0000100_00000_0000_0, 10'h000, 32'h0, 32'h0, 1'b1, 20'h00C00, 12'h020, 8'd5},  // R5 syscall
    '{17'b0000000_00010_0000_0, 10'h000, 32'h0, 32'h0, 1'b1, 20'h00D00, 12'h040, 8'd6},  // R6 step
    '{17'b0000010_00001_0000_0, 10'h000, 32'h0, 32'h0, 1'b1, 20'h00D00, 12'h040, 8'd6},  // R6 branch trace
    '{17'b0000010_00000_0000_0, 10'h000, 32'h0, 32'h0, 1'b0, 20'h00000, 12'h000, 8'd6},  // R6 branch no trace
    '{17'b0000000_00000_1000_0, 10'h000, 32'h0, 32'h0, 1'b1, 20'h01000, 12'h080, 8'd7},  // R7 itlb
    '{17'b0000000_00000_0100_0, 10'h000, 32'h0, 32'h0, 1'b1, 20'h01100, 12'h100, 8'd7},  // R7 load miss
    '{17'b0000000_00000_0010_0, 10'h000, 32'h0, 32'h0, 1'b1, 20'h01200, 12'h200, 8'd7},  // R7 store miss
    '{17'b0000000_00000_0001_0, 10'h000, 32'h0, 32'h0, 1'b1, 20'h01200, 12'h200, 8'd7},  // R7 store dirty hit
    '{17'b0000000_00000_0000_0, 10'h000, 32'h00001237, 32'h00001234, 1'b1, 20'h01300, 12'h400, 8'd8},  // R8 match
    '{17'b0000000_00000_0000_0, 10'h000, 32'h00001235, 32'h00001234, 1'b0, 20'h00000, 12'h000, 8'd8},  // R8 disabled
    '{17'b0000000_00000_0000_0, 10'h000, 32'h00001243, 32'h00001234, 1'b0, 20'h00000, 12'h000, 8'd8},  // R8 mismatch
    '{17'b0000000_00100_0000_1, 10'h000, 32'h0, 32'h0, 1'b1, 20'h01400, 12'h800, 8'd9},  // R9 smi enabled
    '{17'b0000000_00000_0000_1, 10'h000, 32'h0, 32'h0, 1'b0, 20'h00000, 12'h000, 8'd9},  // R9 smi masked
    '{17'b1000100_00110_1000_1, 10'h000, 32'h0, 32'h0, 1'b1, 20'h01000, 12'h080, 8'd12}, // R12 itlb top
    '{17'b1001000_00000_0000_0, 10'h000, 32'h0, 32'h0, 1'b1, 20'h00700, 12'h001, 8'd12}, // R12 program over fp
    '{17'b0000100_00010_0000_0, 10'h000, 32'h0, 32'h0, 1'b1, 20'h00C00, 12'h020, 8'd12}, // R12 syscall over trace
    '{17'b0000000_00110_0000_1, 10'h000, 32'h00001237, 32'h00001234, 1'b1, 20'h00D00, 12'h040, 8'd12}, // R12 trace over bp
    '{17'b0000000_00100_0000_1, 10'h000, 32'h00001237, 32'h00001234, 1'b1, 20'h01300, 12'h400, 8'd12}, // R12 bp over smi
    '{17'b0000000_00000_0110_0, 10'h000, 32'h0, 32'h0, 1'b1, 20'h01100, 12'h100, 8'd12}  // R12 load over store
  };

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic dc_illegal, dc_priv, dc_trap, dc_fpop, dc_syscall, dc_branch, dc_sprmove;
  logic [9:0] dc_sprnum;
  logic ms_user, ms_fpen, ms_irqen, ms_step, ms_brtrace, dec_top;
  logic itlb_miss, dtlb_ld_miss, dtlb_st_miss, dtlb_st_dirty, mgmt_irq;
  logic [31:0] bp_reg, cmp_addr;
  logic        take_exc;
  logic [19:0] vec_off;
  logic [11:0] cause;
  int checks = 0;
  int errors = 0;

  always #(CLK_P/2) clk = ~clk;

  exc_vector_unit u_dut (
    .clk(clk), .rst(rst), .dc_illegal(dc_illegal), .dc_priv(dc_priv),
    .dc_trap(dc_trap), .dc_fpop(dc_fpop), .dc_syscall(dc_syscall),
    .dc_branch(dc_branch), .dc_sprmove(dc_sprmove), .dc_sprnum(dc_sprnum),
    .ms_user(ms_user), .ms_fpen(ms_fpen), .ms_irqen(ms_irqen),
    .ms_step(ms_step), .ms_brtrace(ms_brtrace), .dec_top(dec_top),
    .itlb_miss(itlb_miss), .dtlb_ld_miss(dtlb_ld_miss),
    .dtlb_st_miss(dtlb_st_miss), .dtlb_st_dirty(dtlb_st_dirty),
    .bp_reg(bp_reg), .cmp_addr(cmp_addr), .mgmt_irq(mgmt_irq),
    .take_exc(take_exc), .vec_off(vec_off), .cause(cause)
  );

  task automatic drive(input vec_t v);
    {dc_illegal, dc_priv, dc_trap, dc_fpop, dc_syscall, dc_branch, dc_sprmove,
     ms_user, ms_fpen, ms_irqen, ms_step, ms_brtrace,
     itlb_miss, dtlb_ld_miss, dtlb_st_miss, dtlb_st_dirty, mgmt_irq} = v.fl;
    dc_sprnum = v.spr;
    bp_reg    = v.bk;
    cmp_addr  = v.na;
  endtask

  task automatic chk(input string tag, input logic tk, input logic [19:0] vec,
                     input logic [11:0] cs);
    checks++;
    if (take_exc !== tk || vec_off !== vec || cause !== cs) begin
      errors++;
      $display("FAIL %s: actual take=%0b vec=%h cause=%h expected take=%0b vec=%h cause=%h",
               tag, take_exc, vec_off, cause, tk, vec, cs);
    end
  endtask

  task automatic step_chk(input string tag, input logic tk, input logic [19:0] vec,
                          input logic [11:0] cs);
    @(negedge clk);
    chk(tag, tk, vec, cs);
  endtask

  initial begin
    #(CLK_P * 20000);
    errors++;
    $display("FAIL R1 watchdog: actual=hung expected=finished");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    drive('0);
    dec_top    = 1'b0;
    dc_illegal = 1'b1;  // R1: active cause held during reset
    repeat (3) @(negedge clk);
    chk("R1 reset clears outputs", 1'b0, 20'h0, 12'h0);
    rst = 1'b0;
    drive('0);
    step_chk("R1 idle after reset", 1'b0, 20'h0, 12'h0);

    for (int i = 0; i < NV; i++) begin
      drive(TBL[i]);
      @(negedge clk);
      chk($sformatf("R%0d row %0d", TBL[i].req, i), TBL[i].tk, TBL[i].vec, TBL[i].cs);
    end

    // R10: edge with enable set
    drive('0);
    ms_irqen = 1'b1;
    step_chk("R10 pre", 1'b0, 20'h0, 12'h0);
    dec_top = 1'b1;
    step_chk("R10 rising edge", 1'b1, 20'h00900, 12'h010);
    step_chk("R10 held level no retrigger", 1'b0, 20'h0, 12'h0);
    dec_top = 1'b0;
    step_chk("R10 fall", 1'b0, 20'h0, 12'h0);

    // R11: blocked by enable, then released
    ms_irqen = 1'b0;
    dec_top  = 1'b1;
    step_chk("R11 blocked edge", 1'b0, 20'h0, 12'h0);
    step_chk("R11 still blocked", 1'b0, 20'h0, 12'h0);
    ms_irqen = 1'b1;
    step_chk("R11 pending taken", 1'b1, 20'h00900, 12'h010);
    step_chk("R11 pending cleared", 1'b0, 20'h0, 12'h0);

    // R12/R11: decrementer and management interrupt in the same cycle
    dec_top = 1'b0;
    step_chk("R12 pre collision", 1'b0, 20'h0, 12'h0);
    dec_top  = 1'b1;
    mgmt_irq = 1'b1;
    step_chk("R12 smi beats decrementer", 1'b1, 20'h01400, 12'h800);
    mgmt_irq = 1'b0;
    step_chk("R11 decrementer served after smi", 1'b1, 20'h00900, 12'h010);
    step_chk("R11 nothing left", 1'b0, 20'h0, 12'h0);

    // R10: high level across reset is not an edge
    dec_top = 1'b0;
    @(negedge clk);
    rst     = 1'b1;
    dec_top = 1'b1;
    repeat (2) @(negedge clk);
    chk("R1 reset with ms_irqen", 1'b0, 20'h0, 12'h0);
    rst = 1'b0;
    step_chk("R10 level through reset ignored", 1'b0, 20'h0, 12'h0);
    step_chk("R13 quiet afterwards", 1'b0, 20'h0, 12'h0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule